// File: doc/BRIEF.md
# Strobe-Activated Power Mode Controller

This block holds the power state of a receive/transmit radio front end. A 4-bit power code arrives from the serial configuration logic together with a one-cycle load strobe. The code is parked in a pending register and takes effect only when the external activation strobe (PCA) rises, so software can prepare a change early and hardware can time it exactly. One code is the exception: the alternating mode takes effect as soon as it is loaded. After that the PCA level itself chooses between the receive and the transmit section, with no further serial traffic.

From the active state the block drives one enable for each section: receive, transmit, receive PLL, transmit PLL, RSSI, voltage reference and receive VCO. It also produces a combined lock indication. That output is the external UHF lock input gated with either the receive-PLL or the transmit-PLL lock, as chosen by a select input. PCA is asynchronous and passes through a synchroniser of `SYNC_STAGES` flip-flops. Activation uses the rising edge of the synchronised level.

Top module: `pca_power_ctrl`

## Requirements
- R1: After reset the mode is deep sleep, both PLL keep flags and the RSSI select are clear, and the pending code is 0000. With `fmRx`=0, every section enable is 0.
- R2: A code loaded with `codeLoad`, other than 0101, leaves every output unchanged until the next rising edge of the synchronised PCA.
- R3: On a PCA rising edge the pending code sets the mode. 0000 is deep sleep (all off). 0100 is standby (reference only). 0010 turns on transmit, 0110 turns on receive and 0001 turns on both. The reference is on in every mode except deep sleep.
- R4: Loading 0101 selects the alternating mode in the same cycle, without PCA. In that mode receive is on while synchronised PCA is 0 and transmit is on while it is 1, and the reference stays on.
- R5: PCA-activated code 1000 sets the transmit-PLL keep flag and 1100 clears it. 1010 sets the receive-PLL keep flag and 1110 clears it. A PLL enable is on when its section is on, or in standby when its keep flag is set. In deep sleep both PLLs are off.
- R6: PCA-activated code 0011 selects RSSI on and 0111 selects RSSI off. `rssiEn` is on only while receive is on, and then only if `fmRx`=1 or RSSI on is selected.
- R7: `lockOut` = `uhfLock` AND (`lockSelTx` ? `txPllLock` : `rxPllLock`).
- R8: `rxVcoEn` is `rxPllEn` forced low while `loPwrDn`=1.
- R9: If a load and a PCA rising edge fall in the same cycle, the edge activates the code that was held before the load. The new code stays pending for the next edge.
- R10: Activating the undefined codes 1001, 1011, 1101 and 1111 changes no state.
- R11: A falling edge of PCA activates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| codeIn | input | 4 | Power code from the serial register |
| codeLoad | input | 1 | One-cycle strobe that captures `codeIn` |
| pcaIn | input | 1 | Asynchronous activation strobe |
| fmRx | input | 1 | Receive path runs in FM demodulation mode |
| loPwrDn | input | 1 | Force the receive VCO off |
| lockSelTx | input | 1 | 1 gates transmit-PLL lock, 0 gates receive-PLL lock |
| uhfLock | input | 1 | External UHF synthesiser lock |
| rxPllLock | input | 1 | Receive PLL lock |
| txPllLock | input | 1 | Transmit PLL lock |
| rxEn | output | 1 | Receive section enable |
| txEn | output | 1 | Transmit section enable |
| rxPllEn | output | 1 | Receive PLL enable |
| txPllEn | output | 1 | Transmit PLL enable |
| rssiEn | output | 1 | RSSI circuit enable |
| vrefEn | output | 1 | Voltage reference enable |
| rxVcoEn | output | 1 | Receive VCO enable |
| lockOut | output | 1 | Combined lock indication |

## Verification
A serial load and a PCA activation edge can fall in the same clock cycle. The two must not mix: the edge takes the old pending code and the new one waits. The bench provokes this case by raising PCA and then driving the load strobe exactly two edges later, in the cycle where the synchronised rising edge is seen. It judges the result twice: at the ports the old mode must appear at once, and the loaded mode must appear only after a second PCA pulse. All sixteen codes are swept in several orders, and `fmRx`/`loPwrDn` are varied at every step.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [2:0] {
    MODE_SLEEP, MODE_STANDBY, MODE_TX, MODE_RX, MODE_DUPLEX, MODE_ALT
  } pwrMode_e;

  localparam logic [CODE_W-1:0] CODE_SLEEP      = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_STANDBY    = 4'b0100;
  localparam logic [CODE_W-1:0] CODE_TX         = 4'b0010;
  localparam logic [CODE_W-1:0] CODE_RX         = 4'b0110;
  localparam logic [CODE_W-1:0] CODE_DUPLEX     = 4'b0001;
  localparam logic [CODE_W-1:0] CODE_ALT        = 4'b0101;
  localparam logic [CODE_W-1:0] CODE_RSSI_ON    = 4'b0011;
  localparam logic [CODE_W-1:0] CODE_RSSI_OFF   = 4'b0111;
  localparam logic [CODE_W-1:0] CODE_TXPLL_KEEP = 4'b1000;
  localparam logic [CODE_W-1:0] CODE_TXPLL_DROP = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_RXPLL_KEEP = 4'b1010;
  localparam logic [CODE_W-1:0] CODE_RXPLL_DROP = 4'b1110;

  typedef struct packed {
    logic apply;     // synchronised PCA rising edge
    logic altLoad;   // alternating-mode code being loaded
    logic pcaLevel;  // synchronised PCA level
  } pcpStrobe_t;
endpackage

// File: rtl/pcp_ctrl.sv
module pcp_ctrl
  import pcp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pcaIn,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              codeLoad,
  output pcpStrobe_t        strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic pcaPrev;
  logic pcaNow;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= pcaIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  assign pcaNow = syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcaPrev <= 1'b0;
    else       pcaPrev <= pcaNow;
  end

  always_comb begin
    strobe.apply    = pcaNow & ~pcaPrev;
    strobe.altLoad  = codeLoad && (codeIn == CODE_ALT);
    strobe.pcaLevel = pcaNow;
  end

  // R11
  applyOnce_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.apply |=> !strobe.apply);
endmodule

// File: rtl/pcp_path.sv
module pcp_path
  import pcp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pcpStrobe_t        strobe,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              codeLoad,
  input  logic              fmRx,
  input  logic              loPwrDn,
  input  logic              lockSelTx,
  input  logic              uhfLock,
  input  logic              rxPllLock,
  input  logic              txPllLock,
  output logic              rxEn,
  output logic              txEn,
  output logic              rxPllEn,
  output logic              txPllEn,
  output logic              rssiEn,
  output logic              vrefEn,
  output logic              rxVcoEn,
  output logic              lockOut
);
  logic [CODE_W-1:0] pendingQ;
  pwrMode_e modeQ, modeNext;
  logic rxKeepQ, txKeepQ, rssiSelQ;
  logic rxKeepNext, txKeepNext, rssiSelNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pendingQ <= CODE_SLEEP;
    else if (codeLoad) pendingQ <= codeIn;
  end

  always_comb begin
    modeNext    = modeQ;
    rxKeepNext  = rxKeepQ;
    txKeepNext  = txKeepQ;
    rssiSelNext = rssiSelQ;
    if (strobe.apply) begin
      case (pendingQ)
        CODE_SLEEP:      modeNext = MODE_SLEEP;
        CODE_STANDBY:    modeNext = MODE_STANDBY;
        CODE_TX:         modeNext = MODE_TX;
        CODE_RX:         modeNext = MODE_RX;
        CODE_DUPLEX:     modeNext = MODE_DUPLEX;
        CODE_ALT:        modeNext = MODE_ALT;
        CODE_RSSI_ON:    rssiSelNext = 1'b1;
        CODE_RSSI_OFF:   rssiSelNext = 1'b0;
        CODE_TXPLL_KEEP: txKeepNext = 1'b1;
        CODE_TXPLL_DROP: txKeepNext = 1'b0;
        CODE_RXPLL_KEEP: rxKeepNext = 1'b1;
        CODE_RXPLL_DROP: rxKeepNext = 1'b0;
        default:         ;
      endcase
    end
    if (strobe.altLoad) modeNext = MODE_ALT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= MODE_SLEEP;
      rxKeepQ  <= 1'b0;
      txKeepQ  <= 1'b0;
      rssiSelQ <= 1'b0;
    end else begin
      modeQ    <= modeNext;
      rxKeepQ  <= rxKeepNext;
      txKeepQ  <= txKeepNext;
      rssiSelQ <= rssiSelNext;
    end
  end

  logic inStandby;
  always_comb begin
    inStandby = (modeQ == MODE_STANDBY);
    rxEn    = (modeQ == MODE_RX) || (modeQ == MODE_DUPLEX) ||
              ((modeQ == MODE_ALT) && !strobe.pcaLevel);
    txEn    = (modeQ == MODE_TX) || (modeQ == MODE_DUPLEX) ||
              ((modeQ == MODE_ALT) && strobe.pcaLevel);
    vrefEn  = (modeQ != MODE_SLEEP);
    rxPllEn = rxEn || (inStandby && rxKeepQ);
    txPllEn = txEn || (inStandby && txKeepQ);
    rssiEn  = rxEn && (fmRx || rssiSelQ);
    rxVcoEn = rxPllEn && !loPwrDn;
    lockOut = uhfLock && (lockSelTx ? txPllLock : rxPllLock);
  end

  // R2
  modeStable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.apply && !strobe.altLoad) |=> $stable(modeQ));
  // R3
  vrefWithSection_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxEn || txEn) |-> vrefEn);
  // R4
  altExclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_ALT) |-> (rxEn ^ txEn));
  // R5
  sleepPllOff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SLEEP) |-> (!rxPllEn && !txPllEn));
  // R6
  rssiNeedsRx_chk: assert property (@(posedge clk) disable iff (!rstN)
    rssiEn |-> rxEn);
  // R7
  lockNeedsUhf_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockOut |-> uhfLock);
  // R8
  vcoNeedsPll_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxVcoEn |-> (rxPllEn && !loPwrDn));
endmodule

// File: rtl/pca_power_ctrl.sv
module pca_power_ctrl
  import pcp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  codeIn,
  input  logic        codeLoad,
  input  logic        pcaIn,
  input  logic        fmRx,
  input  logic        loPwrDn,
  input  logic        lockSelTx,
  input  logic        uhfLock,
  input  logic        rxPllLock,
  input  logic        txPllLock,
  output logic        rxEn,
  output logic        txEn,
  output logic        rxPllEn,
  output logic        txPllEn,
  output logic        rssiEn,
  output logic        vrefEn,
  output logic        rxVcoEn,
  output logic        lockOut
);
  pcpStrobe_t strobe;

  pcp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .pcaIn(pcaIn), .codeIn(codeIn),
    .codeLoad(codeLoad), .strobe(strobe)
  );

  pcp_path uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .codeIn(codeIn),
    .codeLoad(codeLoad), .fmRx(fmRx), .loPwrDn(loPwrDn),
    .lockSelTx(lockSelTx), .uhfLock(uhfLock), .rxPllLock(rxPllLock),
    .txPllLock(txPllLock), .rxEn(rxEn), .txEn(txEn), .rxPllEn(rxPllEn),
    .txPllEn(txPllEn), .rssiEn(rssiEn), .vrefEn(vrefEn),
    .rxVcoEn(rxVcoEn), .lockOut(lockOut)
  );
endmodule

// File: tb/sim_pca_power_ctrl.sv
module sim_pca_power_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] codeIn = 4'd0;
  logic codeLoad = 1'b0, pcaIn = 1'b0, fmRx = 1'b0, loPwrDn = 1'b0;
  logic lockSelTx = 1'b0, uhfLock = 1'b0, rxPllLock = 1'b0, txPllLock = 1'b0;
  logic rxEn, txEn, rxPllEn, txPllEn, rssiEn, vrefEn, rxVcoEn, lockOut;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the power state (0 sleep,1 standby,2 tx,3 rx,4 duplex,5 alt)
  int mMode = 0;
  bit mRk = 0, mTk = 0, mRs = 0;
  logic [3:0] mPend = 4'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pca_power_ctrl u0 (
    .clk(clk), .rstN(rstN), .codeIn(codeIn), .codeLoad(codeLoad),
    .pcaIn(pcaIn), .fmRx(fmRx), .loPwrDn(loPwrDn), .lockSelTx(lockSelTx),
    .uhfLock(uhfLock), .rxPllLock(rxPllLock), .txPllLock(txPllLock),
    .rxEn(rxEn), .txEn(txEn), .rxPllEn(rxPllEn), .txPllEn(txPllEn),
    .rssiEn(rssiEn), .vrefEn(vrefEn), .rxVcoEn(rxVcoEn), .lockOut(lockOut)
  );

  function automatic void applyModel(logic [3:0] c);
    case (c)
      4'b0000: mMode = 0;
      4'b0100: mMode = 1;
      4'b0010: mMode = 2;
      4'b0110: mMode = 3;
      4'b0001: mMode = 4;
      4'b0101: mMode = 5;
      4'b0011: mRs = 1;
      4'b0111: mRs = 0;
      4'b1000: mTk = 1;
      4'b1100: mTk = 0;
      4'b1010: mRk = 1;
      4'b1110: mRk = 0;
      default: ;  // R10: undefined codes leave state alone
    endcase
  endfunction

  function automatic logic [7:0] expVec();
    bit rx, tx, rxP, txP;
    rx  = (mMode == 3) || (mMode == 4) || (mMode == 5 && !pcaIn);
    tx  = (mMode == 2) || (mMode == 4) || (mMode == 5 && pcaIn);
    rxP = rx || (mMode == 1 && mRk);
    txP = tx || (mMode == 1 && mTk);
    return {rx, tx, rxP, txP, rx && (fmRx || mRs), mMode != 0,
            rxP && !loPwrDn, uhfLock && (lockSelTx ? txPllLock : rxPllLock)};
  endfunction

  task automatic checkNow(string tag);
    logic [7:0] act, exp;
    #1;
    act = {rxEn, txEn, rxPllEn, txPllEn, rssiEn, vrefEn, rxVcoEn, lockOut};
    exp = expVec();
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s mode=%0d fm=%0b lpd=%0b act=%b exp=%b",
               tag, mMode, fmRx, loPwrDn, act, exp);
    end
  endtask

  // R8: loPwrDn (and fmRx for R6) are swept at every checkpoint
  task automatic checkAll(string tag);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      fmRx = k[0];
      loPwrDn = k[1];
      checkNow(tag);
    end
    fmRx = 0;
    loPwrDn = 0;
  endtask

  task automatic loadCode(logic [3:0] c);
    @(negedge clk);
    codeIn = c;
    codeLoad = 1'b1;
    @(negedge clk);
    codeLoad = 1'b0;
    mPend = c;
    if (c == 4'b0101) mMode = 5;
  endtask

  function automatic string applyTag(logic [3:0] c);
    if (c == 4'b0101) return "R4";
    if (c == 4'b0011 || c == 4'b0111) return "R6";
    if (c[3] && !c[0]) return "R5";
    if (c[3]) return "R10";
    return "R3";
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkNow("R1");
    rstN = 1'b1;
    checkAll("R1");

    for (int pass = 0; pass < 3; pass++) begin
      for (int i = 0; i < 16; i++) begin
        logic [3:0] c;
        c = (pass == 1) ? 4'(15 - i) : 4'((i * 7 + pass) % 16);
        loadCode(c);
        checkAll((c == 4'b0101) ? "R4" : "R2");
        @(negedge clk);
        pcaIn = 1'b1;
        repeat (4) @(negedge clk);
        applyModel(mPend);
        checkAll(applyTag(mPend));
        pcaIn = 1'b0;
        repeat (4) @(negedge clk);
        checkAll("R11");
      end
    end

    // R7: combined lock over all input combinations
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      {uhfLock, lockSelTx, rxPllLock, txPllLock} = 4'(v);
      checkNow("R7");
    end
    {uhfLock, lockSelTx, rxPllLock, txPllLock} = 4'b0;

    // R9: load collides with the activation edge
    loadCode(4'b0110);
    @(negedge clk); pcaIn = 1'b1;
    repeat (4) @(negedge clk);
    applyModel(mPend);
    pcaIn = 1'b0;
    repeat (4) @(negedge clk);
    loadCode(4'b0001);
    @(negedge clk);
    pcaIn = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    codeIn = 4'b0010;
    codeLoad = 1'b1;
    @(negedge clk);
    codeLoad = 1'b0;
    applyModel(4'b0001);
    mPend = 4'b0010;
    checkAll("R9");
    pcaIn = 1'b0;
    repeat (4) @(negedge clk);
    checkAll("R9");
    pcaIn = 1'b1;
    repeat (4) @(negedge clk);
    applyModel(mPend);
    checkAll("R9");
    pcaIn = 1'b0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule